// File: doc/BRIEF.md
# Clock Generator Frequency-Select and Test-Clock Divider

This block sits behind the output drivers of a system clock generator. It takes a speed select (fast/slow processor clock) and a two-bit code, registers them on the reference clock, and decodes the result into one of four behaviours. Code 000 places every clock group in high impedance, so a board tester can drive the nets. Code 100 is a test mode: every group is derived from a test clock that is driven in on the crystal input. Codes 010 and 110 stop the 48 MHz synthesizer and float its output, and flag centre-spread operation. The remaining codes are normal operation.

For each of six output groups the block picks a source: the normal clock, which arrives as an input from the analog synthesizers; high impedance, modelled by a low output-enable with the clock value held at 0; or the test-derived clock. The test clock is sampled in the reference domain. Its rising edges advance a single binary counter whose bits give the divided clocks, so all derived clocks stay phase-aligned. The counter starts from zero each time test mode is entered.

Top module: `fsel_clock_mux`

## Requirements
- R1: With the registered select equal to {fast, code} = 000, every `*_oe` is 0, every `*_clk` is 0, `usbpll_en` is 0 and `spread_on` is 0, whatever the normal clock inputs do.
- R2: With the registered select equal to 100, all enables are 1, `spread_on` is 0, `usbpll_en` is 1, `ref_clk` equals `tst_clk`, and with n the count of `tst_clk` rising edges since test-mode entry: `cpu_clk` = n bit 0, `mid_clk` = n bit 1, `bus_clk` = n bit 2, `apic_clk` = n bit 3, `usb_clk` = n bit 0.
- R3: With the registered code (bits 1:0) equal to 10, regardless of the fast bit, `usb_oe` is 0 and `usb_clk` is 0, `usbpll_en` is 0, `spread_on` is 1, and all other groups pass their normal inputs with enable 1.
- R4: With the registered select equal to 001, 011, 101 or 111, all enables are 1, `usbpll_en` is 1, `spread_on` is 0, `cpu_clk` follows `cpu133_in` when the fast bit is 1 and `cpu100_in` when it is 0, and each other group follows its own normal input.
- R5: The divided test clocks come from one counter; a group's test clock changes only when every lower-division clock falls in the same step, and the count wraps to zero after 16 rising edges.
- R6: The divider count is zero on every entry into test mode, including re-entry after leaving it with a nonzero count.
- R7: A new select value takes effect at the first rising `clk` edge after it is applied; until that edge the previous mode persists.
- R8: While `rst_n` is low at a `clk` edge, the registered select is cleared to 000, so all groups are in high impedance as in R1.
- R9: In test mode, the normal clock inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; registers the select and samples the test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_fast | input | 1 | Processor speed select: 1 fast, 0 slow |
| sel_code | input | 2 | Two-bit mode code |
| cpu100_in | input | 1 | Normal slow processor clock |
| cpu133_in | input | 1 | Normal fast processor clock |
| mid_in | input | 1 | Normal 66 MHz clock |
| bus_in | input | 1 | Normal 33 MHz bus clock |
| apic_in | input | 1 | Normal interrupt-controller clock |
| usb_in | input | 1 | Normal 48 MHz clock |
| ref_in | input | 1 | Normal 14.318 MHz reference output clock |
| tst_clk | input | 1 | Test clock driven in on the crystal input |
| cpu_clk | output | 1 | Processor group clock |
| cpu_oe | output | 1 | Processor group enable (0 = high impedance) |
| mid_clk | output | 1 | 66 MHz group clock |
| mid_oe | output | 1 | 66 MHz group enable |
| bus_clk | output | 1 | Bus group clock |
| bus_oe | output | 1 | Bus group enable |
| apic_clk | output | 1 | Interrupt-controller group clock |
| apic_oe | output | 1 | Interrupt-controller group enable |
| usb_clk | output | 1 | 48 MHz output clock |
| usb_oe | output | 1 | 48 MHz output enable |
| ref_clk | output | 1 | Reference output clock |
| ref_oe | output | 1 | Reference output enable |
| spread_on | output | 1 | Centre-spread mode status |
| usbpll_en | output | 1 | Enable for the 48 MHz synthesizer |

## Verification
A select change is due one `clk` rising edge after it is driven, so the bench drives it on a falling edge, samples once just after driving to see that the old mode persists, and samples again on the next falling edge for the new mode. Normal-clock pass-through and `ref_clk` in test mode are combinational, so they are sampled 1 ns after the inputs move, in the same cycle. A `tst_clk` rising edge advances the divided clocks at the next `clk` rising edge; the bench raises `tst_clk` on a falling edge, confirms the divided outputs are still unchanged 1 ns later, and expects the incremented count at the following falling edge.

// File: rtl/fsel_pkg.sv
// Shared definitions for the frequency-select block: group indices,
// source selection per group and the registered select layout.
package fsel_pkg;

    localparam int NUM_GROUPS = 6;

    localparam int G_CPU  = 0;
    localparam int G_MID  = 1;
    localparam int G_BUS  = 2;
    localparam int G_APIC = 3;
    localparam int G_USB  = 4;
    localparam int G_REF  = 5;

    // Source that drives one output group.
    typedef enum logic [1:0] {
        SRC_NORM = 2'd0,
        SRC_HIZ  = 2'd1,
        SRC_TEST = 2'd2
    } src_e;

    // Registered select: speed bit above the two-bit code.
    typedef struct packed {
        logic       fast;
        logic [1:0] code;
    } fsel_t;

endpackage

// File: rtl/fsel_decode.sv
// Registers the select inputs on the reference clock and decodes the
// registered value into a source per group plus status controls.
// Assumes the select is static in operation; a change is honoured at the
// next clock edge with no glitch-free guarantee on the outputs.
module fsel_decode
    import fsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_fast,
    input  logic [1:0] sel_code,
    output src_e       src [NUM_GROUPS],
    output logic       cpu_fast,
    output logic       test_en,
    output logic       spread_on,
    output logic       usbpll_en
);

    fsel_t sel_q;

    // Capture the select; reset lands in the all-high-impedance code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= '{fast: sel_fast, code: sel_code};
        end
    end

    // Decode the registered select into per-group sources and controls.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            src[g] = SRC_NORM;
        end
        cpu_fast  = sel_q.fast;
        test_en   = 1'b0;
        spread_on = 1'b0;
        usbpll_en = 1'b1;
        case ({sel_q.fast, sel_q.code})
            3'b000: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    src[g] = SRC_HIZ;
                end
                usbpll_en = 1'b0;
            end
            3'b100: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    src[g] = SRC_TEST;
                end
                test_en = 1'b1;
            end
            default: begin
                if (sel_q.code == 2'b10) begin
                    src[G_USB] = SRC_HIZ;
                    usbpll_en  = 1'b0;
                    spread_on  = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/fsel_tdiv.sv
// Test-clock divider. The test clock is sampled as data in the reference
// domain; each sampled rising edge advances one binary counter whose bits
// are the divided clocks. The count is held at zero outside test mode, so
// it restarts from zero on every entry. Assumes the reference clock is at
// least twice as fast as the test clock.
module fsel_tdiv #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              tst_clk,
    output logic [STAGES-1:0] div
);

    logic tst_prev;
    logic tst_rise;

    assign tst_rise = tst_clk & ~tst_prev;

    // Remember the previous test-clock sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tst_prev <= 1'b0;
        end else begin
            tst_prev <= tst_clk;
        end
    end

    // Advance the shared count on each test-clock rising edge in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_en) begin
            div <= '0;
        end else if (tst_rise) begin
            div <= div + 1'b1;
        end
    end

    // R5: a higher division may only change as the next lower one falls.
    generate
        for (genvar b = 1; b < STAGES; b++) begin : g_phase
            a_r5_phase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
                (test_en && $past(test_en) && (div[b] != $past(div[b])))
                |-> ($past(div[b-1]) && !div[b-1]));
        end
    endgenerate

    // R6: the count is zero right after test mode is entered.
    a_r6_zero_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_en) |-> (div == '0));

endmodule

// File: rtl/fsel_outmux.sv
// Per-group output selection: normal clock, high impedance (enable low,
// value held at 0) or test-derived clock. Purely combinational.
module fsel_outmux
    import fsel_pkg::*;
#(
    parameter int GROUPS = NUM_GROUPS
) (
    input  src_e src      [GROUPS],
    input  logic norm_clk [GROUPS],
    input  logic test_clk [GROUPS],
    output logic out_clk  [GROUPS],
    output logic out_oe   [GROUPS]
);

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            // Select this group's clock and enable from its source code.
            always_comb begin
                unique case (src[g])
                    SRC_NORM: begin out_clk[g] = norm_clk[g]; out_oe[g] = 1'b1; end
                    SRC_TEST: begin out_clk[g] = test_clk[g]; out_oe[g] = 1'b1; end
                    default:  begin out_clk[g] = 1'b0;        out_oe[g] = 1'b0; end
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/fsel_clock_mux.sv
// Top of the frequency-select block: registers and decodes the select,
// divides the test clock and chooses each group's output source.
// Assumes normal-mode clocks arrive from the synthesizers as inputs and
// that DIV_STAGES is at least 4 (the slowest test division is bit 3).
module fsel_clock_mux
    import fsel_pkg::*;
#(
    parameter int DIV_STAGES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_fast,
    input  logic [1:0] sel_code,
    input  logic       cpu100_in,
    input  logic       cpu133_in,
    input  logic       mid_in,
    input  logic       bus_in,
    input  logic       apic_in,
    input  logic       usb_in,
    input  logic       ref_in,
    input  logic       tst_clk,
    output logic       cpu_clk,
    output logic       cpu_oe,
    output logic       mid_clk,
    output logic       mid_oe,
    output logic       bus_clk,
    output logic       bus_oe,
    output logic       apic_clk,
    output logic       apic_oe,
    output logic       usb_clk,
    output logic       usb_oe,
    output logic       ref_clk,
    output logic       ref_oe,
    output logic       spread_on,
    output logic       usbpll_en
);

    localparam int CPU_BIT  = 0;
    localparam int MID_BIT  = 1;
    localparam int BUS_BIT  = 2;
    localparam int APIC_BIT = 3;
    localparam int USB_BIT  = 0;

    src_e                  src     [NUM_GROUPS];
    logic                  cpu_fast;
    logic                  test_en;
    logic [DIV_STAGES-1:0] div;
    logic                  norm_clk [NUM_GROUPS];
    logic                  test_clk [NUM_GROUPS];
    logic                  out_clk  [NUM_GROUPS];
    logic                  out_oe   [NUM_GROUPS];
    logic [2:0]            sel_all;

    assign sel_all = {sel_fast, sel_code};

    fsel_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_fast  (sel_fast),
        .sel_code  (sel_code),
        .src       (src),
        .cpu_fast  (cpu_fast),
        .test_en   (test_en),
        .spread_on (spread_on),
        .usbpll_en (usbpll_en)
    );

    fsel_tdiv #(.STAGES(DIV_STAGES)) u_tdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_en (test_en),
        .tst_clk (tst_clk),
        .div     (div)
    );

    // Gather normal and test sources into per-group arrays.
    always_comb begin
        norm_clk[G_CPU]  = cpu_fast ? cpu133_in : cpu100_in;
        norm_clk[G_MID]  = mid_in;
        norm_clk[G_BUS]  = bus_in;
        norm_clk[G_APIC] = apic_in;
        norm_clk[G_USB]  = usb_in;
        norm_clk[G_REF]  = ref_in;
        test_clk[G_CPU]  = div[CPU_BIT];
        test_clk[G_MID]  = div[MID_BIT];
        test_clk[G_BUS]  = div[BUS_BIT];
        test_clk[G_APIC] = div[APIC_BIT];
        test_clk[G_USB]  = div[USB_BIT];
        test_clk[G_REF]  = tst_clk;
    end

    fsel_outmux #(.GROUPS(NUM_GROUPS)) u_outmux (
        .src      (src),
        .norm_clk (norm_clk),
        .test_clk (test_clk),
        .out_clk  (out_clk),
        .out_oe   (out_oe)
    );

    assign cpu_clk  = out_clk[G_CPU];
    assign cpu_oe   = out_oe[G_CPU];
    assign mid_clk  = out_clk[G_MID];
    assign mid_oe   = out_oe[G_MID];
    assign bus_clk  = out_clk[G_BUS];
    assign bus_oe   = out_oe[G_BUS];
    assign apic_clk = out_clk[G_APIC];
    assign apic_oe  = out_oe[G_APIC];
    assign usb_clk  = out_clk[G_USB];
    assign usb_oe   = out_oe[G_USB];
    assign ref_clk  = out_clk[G_REF];
    assign ref_oe   = out_oe[G_REF];

    // R1: board-test code floats every group and stops the 48 MHz synthesizer.
    a_r1_board_test_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_all) == 3'b000)
        |-> (!cpu_oe && !mid_oe && !bus_oe && !apic_oe && !usb_oe && !ref_oe
             && !usbpll_en && !spread_on));

    // R3: code 10 floats only the 48 MHz output and reports spread mode.
    a_r3_usb_only_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_code) == 2'b10)
        |-> (!usb_oe && cpu_oe && ref_oe && spread_on && !usbpll_en));

    // R4: fast normal code passes the fast processor clock.
    a_r4_fast_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_all) == 3'b101)
        |-> (cpu_oe && cpu_clk == cpu133_in));

    // R4: slow normal code passes the slow processor clock.
    a_r4_slow_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_all) == 3'b001)
        |-> (cpu_oe && cpu_clk == cpu100_in));

    // R2: in test mode the reference output follows the test clock.
    a_r2_ref_is_test: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_all) == 3'b100)
        |-> (ref_oe && ref_clk == tst_clk));

endmodule

// File: tb/fsel_clock_mux_bench.sv
module fsel_clock_mux_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_fast = 1'b1;
    logic [1:0] sel_code = 2'b01;
    logic       cpu100_in = 1'b0, cpu133_in = 1'b0, mid_in = 1'b0, bus_in = 1'b0;
    logic       apic_in = 1'b0, usb_in = 1'b0, ref_in = 1'b0, tst_clk = 1'b0;
    logic       cpu_clk, cpu_oe, mid_clk, mid_oe, bus_clk, bus_oe, apic_clk, apic_oe;
    logic       usb_clk, usb_oe, ref_clk, ref_oe, spread_on, usbpll_en;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    fsel_clock_mux u_fsel_clock_mux (
        .clk(clk), .rst_n(rst_n), .sel_fast(sel_fast), .sel_code(sel_code),
        .cpu100_in(cpu100_in), .cpu133_in(cpu133_in), .mid_in(mid_in),
        .bus_in(bus_in), .apic_in(apic_in), .usb_in(usb_in), .ref_in(ref_in),
        .tst_clk(tst_clk),
        .cpu_clk(cpu_clk), .cpu_oe(cpu_oe), .mid_clk(mid_clk), .mid_oe(mid_oe),
        .bus_clk(bus_clk), .bus_oe(bus_oe), .apic_clk(apic_clk), .apic_oe(apic_oe),
        .usb_clk(usb_clk), .usb_oe(usb_oe), .ref_clk(ref_clk), .ref_oe(ref_oe),
        .spread_on(spread_on), .usbpll_en(usbpll_en)
    );

    // Observed vector: clk/oe pairs for cpu, mid, bus, apic, usb, ref, then spread, pll.
    function automatic logic [13:0] observed();
        return {cpu_clk, cpu_oe, mid_clk, mid_oe, bus_clk, bus_oe, apic_clk, apic_oe,
                usb_clk, usb_oe, ref_clk, ref_oe, spread_on, usbpll_en};
    endfunction

    // Expected vector from the requirements for mode m, count n, test clock t.
    function automatic logic [13:0] expected(input logic [2:0] m, input logic [3:0] n,
                                             input logic t);
        logic c;
        if (m == 3'b000) return 14'b0;
        if (m == 3'b100)
            return {n[0], 1'b1, n[1], 1'b1, n[2], 1'b1, n[3], 1'b1,
                    n[0], 1'b1, t, 1'b1, 1'b0, 1'b1};
        c = m[2] ? cpu133_in : cpu100_in;
        if (m[1:0] == 2'b10)
            return {c, 1'b1, mid_in, 1'b1, bus_in, 1'b1, apic_in, 1'b1,
                    1'b0, 1'b0, ref_in, 1'b1, 1'b1, 1'b0};
        return {c, 1'b1, mid_in, 1'b1, bus_in, 1'b1, apic_in, 1'b1,
                usb_in, 1'b1, ref_in, 1'b1, 1'b0, 1'b1};
    endfunction

    task automatic check(input string req, input logic [13:0] exp);
        logic [13:0] act;
        act = observed();
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_norm(input logic [6:0] v);
        {cpu100_in, cpu133_in, mid_in, bus_in, apic_in, usb_in, ref_in} = v;
        #1;
    endtask

    // Drive a select on a falling edge and wait until it is registered.
    task automatic apply_sel(input logic [2:0] m);
        {sel_fast, sel_code} = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    // R8: reset holds all groups floating even with a normal select applied.
    task automatic t_reset();
        rst_n = 1'b0;
        {sel_fast, sel_code} = 3'b101;
        repeat (3) @(negedge clk);
        set_norm(7'b1111111);
        check("R8 reset floats all", expected(3'b000, 4'd0, 1'b0));
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 first select after reset", expected(3'b101, 4'd0, 1'b0));
    endtask

    // R4: normal codes under several input patterns.
    task automatic t_normal();
        logic [2:0] codes [4] = '{3'b001, 3'b011, 3'b101, 3'b111};
        for (int i = 0; i < 4; i++) begin
            apply_sel(codes[i]);
            set_norm(7'b1010101);
            check("R4 normal pattern A", expected(codes[i], 4'd0, 1'b0));
            set_norm(7'b0101010);
            check("R4 normal pattern B", expected(codes[i], 4'd0, 1'b0));
        end
    endtask

    // R3: codes x10 float only the 48 MHz output.
    task automatic t_usb_hiz();
        for (int f = 0; f < 2; f++) begin
            apply_sel({f[0], 2'b10});
            set_norm(7'b1111111);
            check("R3 usb floats, others run", expected({f[0], 2'b10}, 4'd0, 1'b0));
            set_norm(7'b0110011);
            check("R3 usb floats, pattern B", expected({f[0], 2'b10}, 4'd0, 1'b0));
        end
    endtask

    // R7 and R1: old mode persists until the edge, then everything floats.
    task automatic t_board_hiz();
        apply_sel(3'b101);
        set_norm(7'b1111111);
        sel_fast = 1'b0;
        sel_code = 2'b00;
        #1;
        check("R7 old mode before edge", expected(3'b101, 4'd0, 1'b0));
        @(posedge clk);
        @(negedge clk);
        check("R1 board test floats all", expected(3'b000, 4'd0, 1'b0));
        set_norm(7'b0011100);
        check("R1 inputs ignored while floating", 14'b0);
    endtask

    // R2, R5, R9: test-mode divisions over 20 test-clock periods with wrap.
    task automatic t_test(input int periods);
        logic [3:0] n;
        n = 4'd0;
        tst_clk = 1'b0;
        apply_sel(3'b100);
        check("R6 count zero on entry", expected(3'b100, n, 1'b0));
        for (int i = 0; i < periods; i++) begin
            tst_clk = 1'b1;
            set_norm(7'(i * 37));
            check("R9 normal inputs ignored", expected(3'b100, n, 1'b1));
            @(posedge clk);
            @(negedge clk);
            n = n + 4'd1;
            check("R2 divided clocks after rise", expected(3'b100, n, 1'b1));
            if (n == 4'd0) check("R5 wrap after 16 edges", expected(3'b100, 4'd0, 1'b1));
            tst_clk = 1'b0;
            #1;
            check("R2 ref follows test clock low", expected(3'b100, n, 1'b0));
            @(posedge clk);
            @(negedge clk);
            check("R5 no change on falling test edge", expected(3'b100, n, 1'b0));
        end
    endtask

    // R6: leaving and re-entering test mode restarts the count at zero.
    task automatic t_reentry();
        apply_sel(3'b101);
        set_norm(7'b0000000);
        check("R4 normal after test", expected(3'b101, 4'd0, 1'b0));
        apply_sel(3'b100);
        check("R6 count zero on re-entry", expected(3'b100, 4'd0, 1'b0));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_normal();
        t_usb_hiz();
        t_board_hiz();
        t_test(20);
        t_reentry();
        t_test(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule